// File: doc/BRIEF.md
# Serial Transmitter Core with Transmit Queue

This block turns host words into asynchronous serial frames on one output line. The host writes words through a single-cycle write strobe into a four-entry first-in first-out queue. Whenever the transmitter is idle and the queue holds a word, the transmitter takes the oldest word and sends one frame. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Bit timing comes from an internal baud tick. The tick fires once every `divisor + 1` clock cycles, and every bit lasts 16 ticks. An optional flow-control gate keeps a new frame from starting while the clear-to-send input is low. That input is checked only between frames, so a frame that has started always finishes. A break request holds the line low for 13 bit times and then sends one high stop bit. The block also shows the queue fill level, a sticky overflow flag, and an interrupt level that is high when there is nothing left to send.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, `tx` is 1, `fifo_count` is 0, `fifo_empty` is 1, `overflow` is 0, `busy` is 0 and `tx_empty_irq` is 1.
- R2: A frame is a start bit of 0, then data bit 0 through data bit 7 in that order, then a stop bit of 1. Each bit holds for 16 baud ticks. `tx` changes in the cycle after the transmitter takes a word from the queue.
- R3: A write while `fifo_count` is 4 is dropped and sets `overflow` in the next cycle. `overflow` stays set until `clr_ovf` is pulsed. If a drop and a clear happen in the same cycle, the drop wins.
- R4: When `cfg_nine` is 1, a frame carries data bits 0 through 8 and no parity bit, whatever `cfg_parity` says.
- R5: When `cfg_nine` is 0, `cfg_parity` selects the parity bit, which is sent after the data bits: 2'b01 is even (the bit is the XOR of data bits 7:0), 2'b10 is odd (the inverse of that XOR), and 2'b00 or 2'b11 sends no parity bit.
- R6: When `cfg_two_stop` is 1, each frame ends with two stop bits of 1, each 16 ticks long.
- R7: While `cfg_flow_en` is 1 and `cts` is 0, no new data frame starts. A frame that is already under way finishes normally.
- R8: A one-cycle `break_req` makes the block send 13 bit times of 0 followed by one bit time of 1, once the current frame has ended. A pending break goes ahead of queued words and does not wait for `cts`.
- R9: Words leave the queue in the order they were written. `fifo_count` tracks the queue from 0 to 4, `fifo_full` is 1 at 4 and `fifo_empty` is 1 at 0.
- R10: `tx_empty_irq` is 1 exactly when the queue is empty and no frame or break is in progress.
- R11: The baud tick fires on every clock cycle where the tick counter has reached `divisor`, which gives one tick per `divisor + 1` cycles. The frame and queue settings take effect only at the moment a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Baud divisor; one tick every divisor+1 cycles |
| cfg_nine | input | 1 | 1 selects 9 data bits |
| cfg_parity | input | 2 | 01 even, 10 odd, 00/11 none (8-bit frames only) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_flow_en | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear to send, active high |
| break_req | input | 1 | One-cycle request to send a break |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 9 | Word to queue (bit 8 used only in 9-bit frames) |
| clr_ovf | input | 1 | Clears the overflow flag |
| tx | output | 1 | Serial line, idles high |
| fifo_count | output | 3 | Number of queued words |
| fifo_full | output | 1 | Queue holds 4 words |
| fifo_empty | output | 1 | Queue holds no words |
| overflow | output | 1 | Sticky flag for a dropped write |
| busy | output | 1 | A frame or break is in progress |
| tx_empty_irq | output | 1 | Queue empty and transmitter idle |

## Verification
The bench uses the default parameters: a queue depth of 4, 16 ticks per bit and a 13-bit break. It drives `divisor` to 0 and to 2. With a divisor of 0 every bit lasts exactly 16 cycles, so whole 8-bit, 9-bit and parity frames fit into a short run. With a divisor of 2 the baud tick is no longer aligned with the start of a frame, so the first bit of a frame can last a few cycles less than the rest. Holding `cts` low fills the queue to exactly 4 words, so the full flag and the dropped fifth write can both be observed before any word has left the queue.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int OVS      = 16;
    localparam int BRK_BITS = 13;
    localparam int DATA_W   = 9;
    localparam int FRAME_W  = BRK_BITS + 1;
    localparam int LEN_W    = $clog2(FRAME_W + 1);
    localparam int SUB_W    = $clog2(OVS);

    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } parity_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic frame_t make_frame(logic [DATA_W-1:0] d, logic nine,
                                          logic [1:0] par, logic two);
        frame_t f;
        int     p;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        p = 1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < 8 || nine) begin
                f.bits[p] = d[i];
                p++;
            end
        end
        if (!nine && (par == PAR_EVEN || par == PAR_ODD)) begin
            f.bits[p] = (^d[7:0]) ^ (par == PAR_ODD);
            p++;
        end
        p = p + (two ? 2 : 1);
        f.len = LEN_W'(p);
        return f;
    endfunction

    function automatic frame_t make_break();
        frame_t f;
        f.bits = {1'b1, {BRK_BITS{1'b0}}};
        f.len  = LEN_W'(FRAME_W);
        return f;
    endfunction

endpackage

// File: rtl/stx_baud.sv
module stx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divisor);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/stx_fifo.sv
module stx_fifo
    import stx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       pop,
    input  logic                       clr_ovf,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             push;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign push  = wr_en && !full;
    assign head  = slot[rptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             slot[g] <= '0;
            else if (push && wptr == PTR_W'(g))  slot[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
            if (wr_en && full) overflow <= 1'b1;
            else if (clr_ovf)  overflow <= 1'b0;
        end
    end
endmodule

// File: rtl/stx_framer.sv
module stx_framer
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              q_valid,
    input  logic [DATA_W-1:0] q_data,
    input  logic              cfg_nine,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic              cfg_flow_en,
    input  logic              cts,
    input  logic              break_req,
    output logic              pop,
    output logic              tx,
    output logic              busy,
    output logic              brk_pend
);
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;
    logic [SUB_W-1:0]   sub;
    logic               launch_brk;
    frame_t             nxt;

    assign launch_brk = !busy && brk_pend;
    assign pop        = !busy && !brk_pend && q_valid && (!cfg_flow_en || cts);

    always_comb begin
        if (launch_brk) nxt = make_break();
        else            nxt = make_frame(q_data, cfg_nine, cfg_parity, cfg_two_stop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            tx       <= 1'b1;
            sh       <= '1;
            left     <= '0;
            sub      <= '0;
            brk_pend <= 1'b0;
        end else begin
            brk_pend <= launch_brk ? break_req : (brk_pend | break_req);
            if (launch_brk || pop) begin
                tx   <= nxt.bits[0];
                sh   <= nxt.bits >> 1;
                left <= nxt.len - LEN_W'(1);
                sub  <= '0;
                busy <= 1'b1;
            end else if (busy && tick) begin
                if (sub == SUB_W'(OVS - 1)) begin
                    if (left == '0) begin
                        busy <= 1'b0;
                    end else begin
                        tx   <= sh[0];
                        sh   <= sh >> 1;
                        left <= left - LEN_W'(1);
                        sub  <= '0;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
    import stx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DIV_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DIV_W-1:0]           divisor,
    input  logic                       cfg_nine,
    input  logic [1:0]                 cfg_parity,
    input  logic                       cfg_two_stop,
    input  logic                       cfg_flow_en,
    input  logic                       cts,
    input  logic                       break_req,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       clr_ovf,
    output logic                       tx,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic                       fifo_full,
    output logic                       fifo_empty,
    output logic                       overflow,
    output logic                       busy,
    output logic                       tx_empty_irq
);
    logic              tick;
    logic              pop;
    logic              brk_pend;
    logic [DATA_W-1:0] head;

    stx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
    );

    stx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .clr_ovf(clr_ovf), .head(head), .count(fifo_count), .full(fifo_full),
        .empty(fifo_empty), .overflow(overflow)
    );

    stx_framer u_framer (
        .clk(clk), .rst(rst), .tick(tick), .q_valid(!fifo_empty), .q_data(head),
        .cfg_nine(cfg_nine), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_flow_en(cfg_flow_en), .cts(cts), .break_req(break_req),
        .pop(pop), .tx(tx), .busy(busy), .brk_pend(brk_pend)
    );

    assign tx_empty_irq = fifo_empty && !busy;
endmodule

// File: rtl/stx_checks.sv
module stx_checks #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tx,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic                       fifo_full,
    input logic                       fifo_empty,
    input logic                       overflow,
    input logic                       busy,
    input logic                       tx_empty_irq,
    input logic                       wr_en,
    input logic                       clr_ovf,
    input logic                       cts,
    input logic                       cfg_flow_en,
    input logic                       brk_pend
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // R1: the line rests high whenever nothing is being sent
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R3: the fill level never exceeds the queue depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fifo_full) |=> overflow);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clr_ovf) |=> overflow);

    // R7: a held-off transmitter stays idle unless a break is waiting
    p_cts_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_flow_en && !cts && !brk_pend) |=> !busy);

    // R9: the fill level moves by at most one per cycle
    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == $past(fifo_count)) ||
        (fifo_count == $past(fifo_count) + 1'b1) ||
        (fifo_count == $past(fifo_count) - 1'b1));

    p_full_empty_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_full, fifo_empty}));

    // R10: the empty interrupt only shows with an idle line
    p_irq_idle_r10: assert property (@(posedge clk) disable iff (rst)
        tx_empty_irq |-> (tx && fifo_empty));
endmodule

bind serial_tx_core stx_checks #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .tx(tx), .fifo_count(fifo_count),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow),
    .busy(busy), .tx_empty_irq(tx_empty_irq), .wr_en(wr_en),
    .clr_ovf(clr_ovf), .cts(cts), .cfg_flow_en(cfg_flow_en),
    .brk_pend(brk_pend)
);

// File: tb/sim_serial_tx_core.sv
module sim_serial_tx_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] divisor = 16'd0;
    logic        cfg_nine = 1'b0;
    logic [1:0]  cfg_parity = 2'b00;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_flow_en = 1'b0;
    logic        cts = 1'b1;
    logic        break_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = 9'd0;
    logic        clr_ovf = 1'b0;
    logic        tx;
    logic [2:0]  fifo_count;
    logic        fifo_full, fifo_empty, overflow, busy, tx_empty_irq;

    always #2.5 clk = ~clk;

    serial_tx_core u0 (
        .clk(clk), .rst(rst), .divisor(divisor), .cfg_nine(cfg_nine),
        .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_flow_en(cfg_flow_en), .cts(cts), .break_req(break_req),
        .wr_en(wr_en), .wr_data(wr_data), .clr_ovf(clr_ovf), .tx(tx),
        .fifo_count(fifo_count), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .overflow(overflow), .busy(busy), .tx_empty_irq(tx_empty_irq)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_req = "R2";

    // behavioural reference state
    int m_cnt, m_sub, m_q[$];
    bit m_bits[$];
    bit m_tx, m_busy, m_brk, m_ovf;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void build_frame(int d, bit nine, bit [1:0] par, bit two);
        int n;
        bit p;
        m_bits.delete();
        m_bits.push_back(1'b0);
        n = nine ? 9 : 8;
        p = 1'b0;
        for (int i = 0; i < n; i++) begin
            m_bits.push_back(d[i]);
            if (i < 8) p = p ^ d[i];
        end
        if (!nine && par == 2'b01) m_bits.push_back(p);
        if (!nine && par == 2'b10) m_bits.push_back(!p);
        m_bits.push_back(1'b1);
        if (two) m_bits.push_back(1'b1);
    endfunction

    always @(posedge clk) begin : model
        bit tick, lb, lp, full;
        int head;
        if (rst) begin
            m_cnt = 0; m_sub = 0; m_q.delete(); m_bits.delete();
            m_tx = 1; m_busy = 0; m_brk = 0; m_ovf = 0;
        end else begin
            tick = (m_cnt >= int'(divisor));
            lb   = !m_busy && m_brk;
            lp   = !m_busy && !m_brk && m_q.size() > 0 && (!cfg_flow_en || cts);
            full = (m_q.size() == 4);
            m_cnt = tick ? 0 : m_cnt + 1;
            m_brk = lb ? break_req : (m_brk || break_req);
            if (lb || lp) begin
                if (lb) begin
                    m_bits.delete();
                    repeat (13) m_bits.push_back(1'b0);
                    m_bits.push_back(1'b1);
                end else begin
                    head = m_q.pop_front();
                    build_frame(head, cfg_nine, cfg_parity, cfg_two_stop);
                end
                m_tx = m_bits.pop_front();
                m_busy = 1; m_sub = 0;
            end else if (m_busy && tick) begin
                if (m_sub == 15) begin
                    if (m_bits.size() == 0) m_busy = 0;
                    else begin m_tx = m_bits.pop_front(); m_sub = 0; end
                end else m_sub++;
            end
            if (clr_ovf) m_ovf = 0;
            if (wr_en) begin
                if (full) m_ovf = 1;
                else m_q.push_back(int'(wr_data));
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "tx", tx, m_tx);
            check("R9", "fifo_count", fifo_count, m_q.size());
            check("R9", "fifo_full", fifo_full, m_q.size() == 4);
            check("R3", "overflow", overflow, m_ovf);
            check("R10", "tx_empty_irq", tx_empty_irq, m_q.size() == 0 && !m_busy);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic put(int d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 9'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((m_busy || m_q.size() > 0 || m_brk) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        check("R1", "tx", tx, 1);
        check("R1", "fifo_count", fifo_count, 0);
        check("R1", "fifo_empty", fifo_empty, 1);
        check("R1", "overflow", overflow, 0);
        check("R1", "busy", busy, 0);
        check("R1", "tx_empty_irq", tx_empty_irq, 1);

        // R2: plain 8N1 frames
        cur_req = "R2";
        put(9'h0A5); drain();
        put(9'h03C); put(9'h0FF); drain();

        // R5: even and odd parity, and the no-parity code 11
        cur_req = "R5";
        cfg_parity = 2'b01; put(9'h0B7); drain();
        cfg_parity = 2'b10; put(9'h0B7); drain();
        cfg_parity = 2'b11; put(9'h012); drain();

        // R4: 9-bit frames ignore the parity setting
        cur_req = "R4";
        cfg_nine = 1'b1; cfg_parity = 2'b01; put(9'h1C3); put(9'h001); drain();
        cfg_nine = 1'b0; cfg_parity = 2'b00;

        // R6: two stop bits
        cur_req = "R6";
        cfg_two_stop = 1'b1; put(9'h055); put(9'h0AA); drain();
        cfg_two_stop = 1'b0;

        // R11: slower baud tick, not aligned with frame start
        cur_req = "R11";
        divisor = 16'd2; put(9'h0E1); drain();
        divisor = 16'd0;

        // R7 and R9: hold off with cts low, fill the queue, then overflow
        cur_req = "R7";
        cfg_flow_en = 1'b1; cts = 1'b0;
        @(negedge clk);
        wr_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wr_data = 9'(8'h11 * (i + 1));
            @(negedge clk);
        end
        wr_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R7", "busy while cts low", busy, 0);
        check("R7", "tx while cts low", tx, 1);
        check("R9", "fifo_full", fifo_full, 1);
        check("R3", "overflow after dropped write", overflow, 1);
        clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
        check("R3", "overflow after clear", overflow, 0);
        // release, then drop cts in the middle of the first frame
        cts = 1'b1;
        repeat (30) @(negedge clk);
        cts = 1'b0;
        repeat (200) @(negedge clk);
        check("R7", "first frame completed, queue left", fifo_count, 3);
        check("R7", "no new frame while cts low", busy, 0);
        cts = 1'b1;
        cur_req = "R9";
        drain();

        // R8: break wins over queued data and ignores cts
        cur_req = "R8";
        cts = 1'b0;
        put(9'h066);
        @(negedge clk);
        break_req = 1'b1; @(negedge clk); break_req = 1'b0;
        repeat (12 * 16) @(negedge clk);
        check("R8", "line low deep in break", tx, 0);
        check("R8", "queued word still waiting", fifo_count, 1);
        repeat (40) @(negedge clk);
        check("R8", "stop after break", tx, 1);
        cts = 1'b1;
        drain();
        cfg_flow_en = 1'b0;
        check("R10", "irq after drain", tx_empty_irq, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule